// File: doc/BRIEF.md
# Fixed-Content Ethernet Frame Sender over a 4-bit MII

This block sends one fixed Ethernet frame over the transmit half of a 4-bit media-independent interface. A start request causes the frame to be sent. The frame has these parts, in order:

- the preamble and start-of-frame delimiter;
- a broadcast destination address;
- a fixed source address;
- a two-byte type/length word;
- a run of zero-valued payload octets;
- a CRC-32 frame check sequence.

Every output is registered on the transmit clock that the PHY supplies (25 MHz at 100 Mb/s). The block breaks each byte into two nibbles and sends the low nibble first. It builds the check sequence one nibble at a time, in the same cycle that the nibble is produced. No frame buffer is needed.

Typical uses are link bring-up and PHY checks. A controller pulses `start`, waits until `busy` drops, and can then send the next frame. `busy` also covers a minimum idle gap after the frame. During that gap further requests are dropped.

Top module: `mii_frame_tx`

## Requirements
- R1: While `rst` is high, and after it is released with no start, `nib_valid`, `nib_error` and `busy` are 0 and `nib_out` is 0.
- R2: A start is accepted when `start` is 1 at a rising edge while `busy` is 0. `busy` is 1 after that edge and `nib_valid` is still 0. `nib_valid` rises at the second edge.
- R3: The first 16 nibbles of a frame are fifteen 0x5 nibbles followed by one 0xD nibble.
- R4: Every byte after the delimiter is sent as two nibbles with bits [3:0] first. The destination is six 0xFF bytes. The source address (parameter, default 00:11:22:33:44:55) is sent leftmost byte first.
- R5: The two-byte type word (parameter `ETH_TYPE`) follows the source address, upper byte first. For 0x0806 the nibbles are 0x8, 0x0, 0x6, 0x0.
- R6: Next come `PAYLOAD_LEN` octets of 0x00 (default 100), which is 200 zero nibbles.
- R7: The frame ends with 8 check nibbles. The CRC uses the reflected polynomial 0xEDB88320 and starts at 0xFFFFFFFF. Bit 0 of each nibble is fed first, over every nibble from the first destination byte through the last payload byte. The CRC result is inverted, and its bits [3:0] are sent first.
- R8: `nib_valid` stays 1 without a gap for exactly 16 + 2·(14 + `PAYLOAD_LEN`) + 8 nibbles and then drops. `nib_out` is 0 whenever `nib_valid` is 0.
- R9: `nib_error` is 0 at all times.
- R10: A start seen while `busy` is 1 is ignored, whether it comes mid-frame or in the idle gap. Let the edge at which `nib_valid` falls be edge 0. Then `busy` is 1 through edge 23, a start at edge 23 is ignored, and a start at edge 24 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock supplied by the PHY |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to send one frame |
| busy | output | 1 | Frame in progress or idle gap still running |
| nib_out | output | 4 | Transmit data nibble |
| nib_valid | output | 1 | Transmit enable |
| nib_error | output | 1 | Transmit error, held low |

## Verification
The frame is tried three ways:
- with a clean single-cycle start;
- with a stray start pulse in the middle of the payload;
- with a start held high through the end of the idle gap, which is the case where the request lands exactly on the first edge that may accept it.

The header nibbles are compared with a fixed table. That table separates low-nibble-first order from high-nibble-first order, and it also catches the wrong number of preamble nibbles. The check nibbles are compared against a byte-wise bit-serial CRC. That comparison would fail on a wrong bit order, a wrong start value, a missing inversion, or a wrong coverage range. The gap test tells a gap that is one edge short apart from one that is one edge long.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam int unsigned PRE_NIBBLES   = 16;
  localparam int unsigned HDR_BYTES     = 14;
  localparam int unsigned FCS_NIBBLES   = 8;

  // one nibble into the reflected CRC register, bit 0 first
  function automatic logic [31:0] crc32_nib(input logic [31:0] c_in, input logic [3:0] d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 4; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

  // byte b of the covered region (destination onward)
  function automatic logic [7:0] frame_byte(input int unsigned b, input logic [47:0] mac,
                                            input logic [15:0] etype);
    if (b < 6)        return 8'hFF;
    else if (b < 12)  return mac[8*(11-b) +: 8];
    else if (b == 12) return etype[15:8];
    else if (b == 13) return etype[7:0];
    else              return 8'h00;
  endfunction

endpackage

// File: rtl/mii_tx_seq.sv
module mii_tx_seq #(
  parameter int unsigned TOTAL_NIB    = 252,
  parameter int unsigned IDLE_NIBBLES = 24,
  localparam int unsigned IDX_W = $clog2(TOTAL_NIB),
  localparam int unsigned GAP_W = $clog2(IDLE_NIBBLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             txen_q,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             frame_start
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_NIB - 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(IDLE_NIBBLES);

  logic [GAP_W-1:0] gap_q;

  assign busy        = active | txen_q | (gap_q != '0);
  assign frame_start = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      gap_q  <= '0;
    end else if (frame_start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      if (idx == LAST_IDX) begin
        active <= 1'b0;
        gap_q  <= GAP_LOAD;
      end else begin
        idx <= idx + 1'b1;
      end
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end
endmodule

// File: rtl/mii_tx_nibble_src.sv
module mii_tx_nibble_src
  import mii_tx_pkg::*;
#(
  parameter int unsigned PAYLOAD_LEN = 100,
  parameter logic [47:0] SRC_ADDR    = 48'h001122334455,
  parameter logic [15:0] ETH_TYPE    = 16'h0806,
  localparam int unsigned DATA_LO   = PRE_NIBBLES,
  localparam int unsigned DATA_HI   = PRE_NIBBLES + 2*(HDR_BYTES + PAYLOAD_LEN),
  localparam int unsigned TOTAL_NIB = DATA_HI + FCS_NIBBLES,
  localparam int unsigned IDX_W     = $clog2(TOTAL_NIB)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      crc_q,
  output logic [3:0]       nib,
  output logic             in_data,
  output logic             in_fcs
);
  logic [IDX_W-1:0] rel;
  logic [IDX_W-1:0] fcs_k;
  logic [7:0]       cur_byte;
  logic [31:0]      fcs_word;

  assign in_data  = (idx >= IDX_W'(DATA_LO)) && (idx < IDX_W'(DATA_HI));
  assign in_fcs   = (idx >= IDX_W'(DATA_HI));
  assign rel      = idx - IDX_W'(DATA_LO);
  assign fcs_k    = idx - IDX_W'(DATA_HI);
  assign cur_byte = frame_byte(32'(rel >> 1), SRC_ADDR, ETH_TYPE);
  assign fcs_word = ~crc_q;

  always_comb begin
    if (in_fcs)
      nib = fcs_word[{fcs_k[2:0], 2'b00} +: 4];
    else if (in_data)
      nib = rel[0] ? cur_byte[7:4] : cur_byte[3:0];
    else if (idx == IDX_W'(DATA_LO - 1))
      nib = 4'hD;
    else
      nib = 4'h5;
  end
endmodule

// File: rtl/mii_tx_crc.sv
module mii_tx_crc
  import mii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_start,
  input  logic        feed,
  input  logic [3:0]  nib,
  output logic [31:0] crc_q
);
  always_ff @(posedge clk) begin
    if (rst)              crc_q <= '1;
    else if (frame_start) crc_q <= '1;
    else if (feed)        crc_q <= crc32_nib(crc_q, nib);
  end
endmodule

// File: rtl/mii_frame_tx.sv
module mii_frame_tx
  import mii_tx_pkg::*;
#(
  parameter int unsigned PAYLOAD_LEN  = 100,
  parameter logic [47:0] SRC_ADDR     = 48'h001122334455,
  parameter logic [15:0] ETH_TYPE     = 16'h0806,
  parameter int unsigned IDLE_NIBBLES = 24
) (
  input  logic       tx_clk,
  input  logic       rst,
  input  logic       start,
  output logic       busy,
  output logic [3:0] nib_out,
  output logic       nib_valid,
  output logic       nib_error
);
  localparam int unsigned TOTAL_NIB = PRE_NIBBLES + 2*(HDR_BYTES + PAYLOAD_LEN) + FCS_NIBBLES;
  localparam int unsigned IDX_W     = $clog2(TOTAL_NIB);

  logic             active;
  logic [IDX_W-1:0] idx;
  logic             frame_start;
  logic [3:0]       nib;
  logic             in_data, in_fcs;
  logic [31:0]      crc_q;
  logic             fcs_nib_evt;
  logic             txen_q;
  logic [3:0]       txd_q;

  assign fcs_nib_evt = active & in_fcs;

  mii_tx_seq #(.TOTAL_NIB(TOTAL_NIB), .IDLE_NIBBLES(IDLE_NIBBLES)) u_seq (
    .clk(tx_clk), .rst(rst), .start(start), .txen_q(txen_q),
    .active(active), .idx(idx), .busy(busy), .frame_start(frame_start)
  );

  mii_tx_nibble_src #(.PAYLOAD_LEN(PAYLOAD_LEN), .SRC_ADDR(SRC_ADDR), .ETH_TYPE(ETH_TYPE)) u_src (
    .idx(idx), .crc_q(crc_q), .nib(nib), .in_data(in_data), .in_fcs(in_fcs)
  );

  mii_tx_crc u_crc (
    .clk(tx_clk), .rst(rst), .frame_start(frame_start),
    .feed(active & in_data), .nib(nib), .crc_q(crc_q)
  );

  always_ff @(posedge tx_clk) begin
    if (rst) begin
      txen_q <= 1'b0;
      txd_q  <= 4'h0;
    end else begin
      txen_q <= active;
      txd_q  <= active ? nib : 4'h0;
    end
  end

  assign nib_valid = txen_q;
  assign nib_out   = txd_q;
  assign nib_error = 1'b0;
endmodule

// File: rtl/mii_frame_tx_checker.sv
module mii_frame_tx_checker (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       txen,
  input logic [3:0] txd,
  input logic       frame_start,
  input logic       fcs_phase
);
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (busy && !txen));
  assert_txen_latency_R2: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> ##2 txen);
  assert_first_nibble_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(txen) |-> (txd == 4'h5));
  assert_idle_data_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !txen |-> (txd == 4'h0));
  assert_fcs_on_wire_R7: assert property (@(posedge clk) disable iff (rst)
    fcs_phase |=> txen);
  assert_busy_covers_tx_R10: assert property (@(posedge clk) disable iff (rst)
    txen |-> busy);
  assert_gap_holds_busy_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(txen) |-> busy);
endmodule

bind mii_frame_tx mii_frame_tx_checker u_chk (
  .clk(tx_clk), .rst(rst), .busy(busy), .txen(nib_valid), .txd(nib_out),
  .frame_start(frame_start), .fcs_phase(fcs_nib_evt)
);

// File: tb/test_mii_frame_tx.sv
module test_mii_frame_tx;
  localparam int N     = 100;
  localparam int TOTAL = 16 + 2*(14 + N) + 8;
  localparam int FCS0  = 16 + 2*(14 + N);

  // expected header nibbles: preamble+SFD (R3), dst+src (R4), type (R5)
  localparam logic [3:0] HDR [0:43] = '{
    4'h5,4'h5,4'h5,4'h5,4'h5,4'h5,4'h5,4'h5,4'h5,4'h5,4'h5,4'h5,4'h5,4'h5,4'h5,4'hD,
    4'hF,4'hF,4'hF,4'hF,4'hF,4'hF,4'hF,4'hF,4'hF,4'hF,4'hF,4'hF,
    4'h0,4'h0,4'h1,4'h1,4'h2,4'h2,4'h3,4'h3,4'h4,4'h4,4'h5,4'h5,
    4'h8,4'h0,4'h6,4'h0};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       busy, nib_valid, nib_error;
  logic [3:0] nib_out;
  int         checks = 0, fails = 0;
  bit         finished = 0;
  logic [3:0] cap [0:TOTAL-1];

  always #5 clk = ~clk;

  mii_frame_tx #(.PAYLOAD_LEN(N), .SRC_ADDR(48'h001122334455), .ETH_TYPE(16'h0806),
                 .IDLE_NIBBLES(24)) i_mii_frame_tx (
    .tx_clk(tx_clk_w), .rst(rst), .start(start), .busy(busy),
    .nib_out(nib_out), .nib_valid(nib_valid), .nib_error(nib_error));

  wire tx_clk_w = clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic capture(input bit mid_pulse);
    int gaps = 0, errs = 0;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R2", "busy after accept", busy, 1);
    check(nib_valid == 1'b0, "R2", "txen one edge after accept", nib_valid, 0);
    @(negedge clk);
    check(nib_valid == 1'b1, "R2", "txen two edges after accept", nib_valid, 1);
    for (int k = 0; k < TOTAL; k++) begin
      if (k > 0) @(negedge clk);
      cap[k] = nib_out;
      if (!nib_valid) gaps++;
      if (nib_error) errs++;
      if (mid_pulse && k == 100) start = 1'b1;
      if (mid_pulse && k == 101) start = 1'b0;
    end
    check(gaps == 0, "R8", "txen gaps inside frame", gaps, 0);
    check(errs == 0, "R9", "txer high cycles", errs, 0);
    @(negedge clk);
    check(nib_valid == 1'b0, "R8", "txen after last nibble", nib_valid, 0);
    check(nib_out == 4'h0, "R8", "txd while idle", nib_out, 0);
  endtask

  task automatic verify_frame();
    logic [7:0]  bytes [0:13+N];
    logic [31:0] c;
    int          nz = 0;
    for (int k = 0; k < 44; k++)
      check(cap[k] == HDR[k], (k < 16) ? "R3" : (k < 40) ? "R4" : "R5",
            $sformatf("header nibble %0d", k), cap[k], HDR[k]);
    for (int k = 44; k < FCS0; k++) if (cap[k] != 4'h0) nz++;
    check(nz == 0, "R6", "nonzero payload nibbles", nz, 0);
    // byte-wise, bit-serial CRC over destination..payload
    for (int b = 0; b < 6; b++) bytes[b] = 8'hFF;
    for (int b = 0; b < 6; b++) bytes[6+b] = 8'(b * 8'h11);
    bytes[12] = 8'h08; bytes[13] = 8'h06;
    for (int b = 14; b < 14 + N; b++) bytes[b] = 8'h00;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 14 + N; b++) begin
      c = c ^ {24'h0, bytes[b]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int k = 0; k < 8; k++)
      check(cap[FCS0+k] == c[4*k +: 4], "R7", $sformatf("fcs nibble %0d", k),
            cap[FCS0+k], c[4*k +: 4]);
  endtask

  initial begin
    int hits;
    repeat (3) @(negedge clk);
    check(nib_valid == 0 && nib_out == 0 && nib_error == 0 && busy == 0, "R1", "outputs in reset",
          {busy, nib_error, nib_valid, nib_out}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(nib_valid == 0 && nib_out == 0 && busy == 0, "R1", "outputs after reset",
          {busy, nib_valid, nib_out}, 0);

    // frame 1: clean pulse
    start = 1'b1;
    capture(1'b0);
    verify_frame();

    // now just after fall edge (edge 0); reach edge 23
    repeat (22) @(negedge clk);
    check(busy == 1'b1, "R10", "busy after edge 22 of gap", busy, 1);
    start = 1'b1;                       // sampled at edge 23
    @(negedge clk);
    check(nib_valid == 1'b0 && busy == 1'b0, "R10", "start at edge 23 ignored",
          {busy, nib_valid}, 0);
    // start still high: sampled at edge 24 -> accepted; stray mid-frame pulse
    capture(1'b1);
    verify_frame();

    hits = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (nib_valid) hits++;
    end
    check(hits == 0, "R10", "frame cycles after mid-frame start", hits, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule